// File: doc/BRIEF.md
# Packed SIMD Saturating Shifter

This block shifts a 32-bit word that is read either as two signed 16-bit lanes, four 8-bit lanes, or one 32-bit lane. Each lane shifts on its own: nothing crosses a lane boundary. The block supports five operations:

- plain left shift, which wraps;
- left shift with clamping;
- arithmetic right shift;
- arithmetic right shift with round-to-nearest;
- logical right shift.

The shift amount comes either from an immediate field or from the low bits of a second register operand. Only the low bits that matter for the lane width are used.

A sticky flag records that some lane was clamped during a clamping left shift. The flag stays set until the surrounding logic pulses the clear input. By default the result passes through one output register, so it appears one cycle after the request. The sticky flag is always registered.

Top module: `simd_shift_unit`

## Requirements
- R1: `fmt_i` selects the lane layout: 0 gives two 16-bit lanes (bits 15:0 and 31:16), 1 gives four 8-bit lanes (bits 8k+7:8k), and 2 or 3 gives a single 32-bit lane. Each lane's result depends only on that lane's input bits.
- R2: When `use_reg_amt_i` is 1 the shift amount is `reg_amt_i`, otherwise it is `imm_amt_i`. The effective amount is its low 4 bits for 16-bit lanes, its low 3 bits for 8-bit lanes, and all 5 bits for the 32-bit lane.
- R3: `op_i` = 0 shifts each lane left by the amount, discarding bits shifted out of the lane and filling with zeros.
- R4: `op_i` = 1 with 16-bit or 32-bit lanes returns the lane value times 2^amount, clamped to the signed lane range. Positive overflow gives the maximum and negative overflow gives the minimum.
- R5: `op_i` = 1 with 8-bit lanes treats each byte as unsigned and clamps any result above 255 to 0xFF.
- R6: `op_i` = 2 gives floor(lane / 2^amount) with the lane read as signed, so vacated high bits copy the lane's sign bit.
- R7: `op_i` = 3 gives floor((lane + 2^(amount-1)) / 2^amount) with the lane read as signed, computed without lane overflow. An amount of 0 returns the lane unchanged.
- R8: `op_i` = 4 shifts each lane right, filling vacated high bits with zeros.
- R9: `sat_flag_o` goes to 1 on the clock edge that accepts an `op_i` = 1 request in which any lane clamps. It stays at 1 until an edge where `sat_clr_i` is 1 and no new clamping request arrives; a new clamp wins over a clear in the same cycle.
- R10: With the output register present (the default), `result_o` and `valid_o` show a request one cycle after `valid_i` is 1. While `valid_i` is 0, `result_o` holds, `valid_o` is 0 and the flag is only affected by `sat_clr_i`.
- R11: While `rst_n` is 0 at a clock edge, `result_o`, `valid_o` and `sat_flag_o` become 0.
- R12: `op_i` codes 5 to 7 produce a zero result and never set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 3 | Operation code (0 shl, 1 shl clamp, 2 sra, 3 sra round, 4 srl) |
| fmt_i | input | 2 | Lane layout (0 halves, 1 bytes, 2/3 word) |
| use_reg_amt_i | input | 1 | 1 takes the amount from `reg_amt_i` |
| imm_amt_i | input | 5 | Immediate shift amount |
| reg_amt_i | input | 5 | Low bits of the register shift operand |
| operand_i | input | 32 | Word to shift |
| sat_clr_i | input | 1 | Clears the sticky clamp flag |
| result_o | output | 32 | Shifted word |
| valid_o | output | 1 | `result_o` holds a new result |
| sat_flag_o | output | 1 | Sticky clamp flag |

## Verification
The assertions check the following on every cycle:

- the flag stays set without a clear, drops after a clear, and cannot rise without a clamping request;
- the valid output follows the request by one cycle;
- the result holds while idle;
- the sign and zero fill of the high bits for immediate-amount arithmetic right shifts on halves and logical right shifts on bytes.

Only the bench's sweeps can show the following:

- the exact lane values under every operation, format and amount;
- the clamp limits;
- the rounding arithmetic;
- that the unused amount source has no effect.

// File: rtl/simd_shift_pkg.sv
// Package: shared encodings and widths for the packed shifter.
// Assumes a 32-bit datapath; lane widths are derived from it.
package simd_shift_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned AMT_W  = $clog2(WORD_W);

    typedef enum logic [2:0] {
        SH_OP_SLL     = 3'd0,
        SH_OP_SLL_SAT = 3'd1,
        SH_OP_SRA     = 3'd2,
        SH_OP_SRA_RND = 3'd3,
        SH_OP_SRL     = 3'd4
    } sh_op_e;

    typedef enum logic [1:0] {
        SH_FMT_HALF = 2'd0,
        SH_FMT_BYTE = 2'd1,
        SH_FMT_WORD = 2'd2,
        SH_FMT_WALT = 2'd3
    } sh_fmt_e;

endpackage

// File: rtl/simd_shift_amt_sel.sv
// Module: picks the shift amount from the immediate or the register operand.
// Assumes both sources already carry only the AMT_W low bits.
module simd_shift_amt_sel #(
    parameter int unsigned AMT_W = 5
) (
    input  logic             use_reg_i,
    input  logic [AMT_W-1:0] imm_i,
    input  logic [AMT_W-1:0] reg_i,
    output logic [AMT_W-1:0] amt_o
);

    // Source select for the raw amount.
    always_comb begin
        amt_o = use_reg_i ? reg_i : imm_i;
    end

endmodule

// File: rtl/simd_shift_lane.sv
// Module: one lane of the packed shifter.
// Performs wrap/clamp left shift, arithmetic right shift with optional
// rounding, and logical right shift. The amount input carries exactly the
// bits that matter for this lane width. SAT_UNSIGNED selects the unsigned
// clamp range instead of the signed range.
module simd_shift_lane
    import simd_shift_pkg::*;
#(
    parameter int unsigned LANE_W       = 16,
    parameter bit          SAT_UNSIGNED = 1'b0,
    localparam int unsigned SH_W        = $clog2(LANE_W)
) (
    input  logic [LANE_W-1:0] lane_i,
    input  logic [SH_W-1:0]   sh_i,
    input  sh_op_e            op_i,
    input  logic              op_ok_i,
    output logic [LANE_W-1:0] lane_o,
    output logic              sat_o
);

    logic [LANE_W-1:0] shl;
    logic [LANE_W-1:0] back;
    logic              ovf;
    logic [LANE_W-1:0] clamp_val;
    logic [LANE_W:0]   wide;
    logic [LANE_W:0]   bias;
    logic [LANE_W:0]   summed;
    logic [LANE_W:0]   rnd_sh;
    logic [LANE_W-1:0] sra_val;
    logic [LANE_W-1:0] srl_val;

    // Left shift and overflow detection by shifting back and comparing.
    always_comb begin
        shl = lane_i << sh_i;
        if (SAT_UNSIGNED) begin
            back = shl >> sh_i;
        end else begin
            back = $unsigned($signed(shl) >>> sh_i);
        end
        ovf = (back != lane_i);
    end

    // Clamp value chosen from the lane's range and sign.
    always_comb begin
        if (SAT_UNSIGNED) begin
            clamp_val = '1;
        end else if (lane_i[LANE_W-1]) begin
            clamp_val = {1'b1, {(LANE_W-1){1'b0}}};
        end else begin
            clamp_val = {1'b0, {(LANE_W-1){1'b1}}};
        end
    end

    // Rounded arithmetic right shift on a value widened by one bit.
    always_comb begin
        wide = {lane_i[LANE_W-1], lane_i};
        bias = '0;
        if (sh_i != '0) begin
            bias[sh_i - 1'b1] = 1'b1;
        end
        summed = wide + bias;
        rnd_sh = $unsigned($signed(summed) >>> sh_i);
    end

    // Plain right shifts.
    always_comb begin
        sra_val = $unsigned($signed(lane_i) >>> sh_i);
        srl_val = lane_i >> sh_i;
    end

    // Operation select for the lane result and its clamp indication.
    always_comb begin
        lane_o = '0;
        sat_o  = 1'b0;
        if (op_ok_i) begin
            unique case (op_i)
                SH_OP_SLL:     lane_o = shl;
                SH_OP_SLL_SAT: begin
                    lane_o = ovf ? clamp_val : shl;
                    sat_o  = ovf;
                end
                SH_OP_SRA:     lane_o = sra_val;
                SH_OP_SRA_RND: lane_o = rnd_sh[LANE_W-1:0];
                SH_OP_SRL:     lane_o = srl_val;
                default:       lane_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/simd_shift_datapath.sv
// Module: combinational packed datapath.
// Builds halfword, byte and word lane arrays in parallel and selects one by
// format. Assumes WORD_W divides evenly into halves and quarters.
module simd_shift_datapath
    import simd_shift_pkg::*;
#(
    parameter int unsigned W     = 32,
    parameter int unsigned AMT_W = 5
) (
    input  logic [W-1:0]     operand_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic [2:0]       op_i,
    input  logic [1:0]       fmt_i,
    output logic [W-1:0]     result_o,
    output logic             sat_o
);

    localparam int unsigned HALF_W  = W / 2;
    localparam int unsigned BYTE_W  = W / 4;
    localparam int unsigned N_HALF  = W / HALF_W;
    localparam int unsigned N_BYTE  = W / BYTE_W;
    localparam int unsigned HSH_W   = $clog2(HALF_W);
    localparam int unsigned BSH_W   = $clog2(BYTE_W);
    localparam int unsigned WSH_W   = $clog2(W);

    sh_op_e            op;
    logic              op_ok;
    logic [W-1:0]      half_res;
    logic [W-1:0]      byte_res;
    logic [W-1:0]      word_res;
    logic [N_HALF-1:0] half_sat;
    logic [N_BYTE-1:0] byte_sat;
    logic              word_sat;

    // Decode of the operation code and its legality.
    always_comb begin
        op    = sh_op_e'(op_i);
        op_ok = (op_i <= 3'd4);
    end

    // Halfword lanes, signed clamp.
    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        simd_shift_lane #(
            .LANE_W      (HALF_W),
            .SAT_UNSIGNED(1'b0)
        ) u_lane (
            .lane_i (operand_i[h*HALF_W +: HALF_W]),
            .sh_i   (amt_i[HSH_W-1:0]),
            .op_i   (op),
            .op_ok_i(op_ok),
            .lane_o (half_res[h*HALF_W +: HALF_W]),
            .sat_o  (half_sat[h])
        );
    end

    // Byte lanes, unsigned clamp.
    for (genvar b = 0; b < N_BYTE; b++) begin : g_byte
        simd_shift_lane #(
            .LANE_W      (BYTE_W),
            .SAT_UNSIGNED(1'b1)
        ) u_lane (
            .lane_i (operand_i[b*BYTE_W +: BYTE_W]),
            .sh_i   (amt_i[BSH_W-1:0]),
            .op_i   (op),
            .op_ok_i(op_ok),
            .lane_o (byte_res[b*BYTE_W +: BYTE_W]),
            .sat_o  (byte_sat[b])
        );
    end

    // Single full-width lane, signed clamp.
    simd_shift_lane #(
        .LANE_W      (W),
        .SAT_UNSIGNED(1'b0)
    ) u_word_lane (
        .lane_i (operand_i),
        .sh_i   (amt_i[WSH_W-1:0]),
        .op_i   (op),
        .op_ok_i(op_ok),
        .lane_o (word_res),
        .sat_o  (word_sat)
    );

    // Format select for the result and the combined clamp indication.
    always_comb begin
        unique case (sh_fmt_e'(fmt_i))
            SH_FMT_HALF: begin
                result_o = half_res;
                sat_o    = |half_sat;
            end
            SH_FMT_BYTE: begin
                result_o = byte_res;
                sat_o    = |byte_sat;
            end
            default: begin
                result_o = word_res;
                sat_o    = word_sat;
            end
        endcase
    end

endmodule

// File: rtl/simd_shift_unit.sv
// Module: top of the packed saturating shifter.
// Selects the amount source, runs the lane datapath, optionally registers
// the result, and keeps a sticky clamp flag. Reset is synchronous, active low.
module simd_shift_unit
    import simd_shift_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [2:0]        op_i,
    input  logic [1:0]        fmt_i,
    input  logic              use_reg_amt_i,
    input  logic [AMT_W-1:0]  imm_amt_i,
    input  logic [AMT_W-1:0]  reg_amt_i,
    input  logic [WORD_W-1:0] operand_i,
    input  logic              sat_clr_i,
    output logic [WORD_W-1:0] result_o,
    output logic              valid_o,
    output logic              sat_flag_o
);

    logic [AMT_W-1:0]  amt;
    logic [WORD_W-1:0] dp_res;
    logic              dp_sat;
    logic              flag_q;

    simd_shift_amt_sel #(
        .AMT_W(AMT_W)
    ) u_amt_sel (
        .use_reg_i(use_reg_amt_i),
        .imm_i    (imm_amt_i),
        .reg_i    (reg_amt_i),
        .amt_o    (amt)
    );

    simd_shift_datapath #(
        .W    (WORD_W),
        .AMT_W(AMT_W)
    ) u_datapath (
        .operand_i(operand_i),
        .amt_i    (amt),
        .op_i     (op_i),
        .fmt_i    (fmt_i),
        .result_o (dp_res),
        .sat_o    (dp_sat)
    );

    // Sticky clamp flag: a new clamp wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (valid_i && dp_sat) begin
            flag_q <= 1'b1;
        end else if (sat_clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign sat_flag_o = flag_q;

    if (REG_OUT) begin : g_reg_out
        logic [WORD_W-1:0] res_q;
        logic              vld_q;

        // Output register: capture on a request, hold otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q <= '0;
                vld_q <= 1'b0;
            end else begin
                vld_q <= valid_i;
                if (valid_i) begin
                    res_q <= dp_res;
                end
            end
        end

        assign result_o = res_q;
        assign valid_o  = vld_q;
    end else begin : g_comb_out
        assign result_o = dp_res;
        assign valid_o  = valid_i;
    end

endmodule

// File: rtl/simd_shift_unit_chk.sv
// Module: property checker for simd_shift_unit, attached by bind.
// Assumes the port encodings of the top module.
module simd_shift_unit_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic [2:0]  op_i,
    input logic [1:0]  fmt_i,
    input logic        use_reg_amt_i,
    input logic [4:0]  imm_amt_i,
    input logic [31:0] operand_i,
    input logic        sat_clr_i,
    input logic [31:0] result_o,
    input logic        valid_o,
    input logic        sat_flag_o
);

    logic clamp_req;
    assign clamp_req = valid_i && (op_i == 3'd1);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag_o && !sat_clr_i) |=> sat_flag_o);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clr_i && !clamp_req) |=> !sat_flag_o);

    // R9
    flag_norise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_flag_o && !clamp_req) |=> !sat_flag_o);

    // R10
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n || !REG_OUT)
        1'b1 |=> (valid_o == $past(valid_i)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !REG_OUT)
        !valid_i |=> $stable(result_o));

    // R8
    srl_byte_fill_chk: assert property (@(posedge clk) disable iff (!rst_n || !REG_OUT)
        (valid_i && op_i == 3'd4 && fmt_i == 2'd1 && !use_reg_amt_i && imm_amt_i[2:0] != 3'd0)
        |=> (!result_o[7] && !result_o[15] && !result_o[23] && !result_o[31]));

    // R6
    sra_half_fill_chk: assert property (@(posedge clk) disable iff (!rst_n || !REG_OUT)
        (valid_i && op_i == 3'd2 && fmt_i == 2'd0 && !use_reg_amt_i && imm_amt_i[3:0] != 4'd0)
        |=> (result_o[15:14] == {2{$past(operand_i[15])}}
             && result_o[31:30] == {2{$past(operand_i[31])}}));

endmodule

bind simd_shift_unit simd_shift_unit_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_i      (valid_i),
    .op_i         (op_i),
    .fmt_i        (fmt_i),
    .use_reg_amt_i(use_reg_amt_i),
    .imm_amt_i    (imm_amt_i),
    .operand_i    (operand_i),
    .sat_clr_i    (sat_clr_i),
    .result_o     (result_o),
    .valid_o      (valid_o),
    .sat_flag_o   (sat_flag_o)
);

// File: tb/simd_shift_unit_bench.sv
module simd_shift_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid_i;
    logic [2:0]  op_i;
    logic [1:0]  fmt_i;
    logic        use_reg_amt_i;
    logic [4:0]  imm_amt_i;
    logic [4:0]  reg_amt_i;
    logic [31:0] operand_i;
    logic        sat_clr_i;
    logic [31:0] result_o;
    logic        valid_o;
    logic        sat_flag_o;

    int checks   = 0;
    int failures = 0;
    bit flag_exp = 1'b0;

    always #2 clk = ~clk;

    simd_shift_unit u_simd_shift_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (valid_i),
        .op_i         (op_i),
        .fmt_i        (fmt_i),
        .use_reg_amt_i(use_reg_amt_i),
        .imm_amt_i    (imm_amt_i),
        .reg_amt_i    (reg_amt_i),
        .operand_i    (operand_i),
        .sat_clr_i    (sat_clr_i),
        .result_o     (result_o),
        .valid_o      (valid_o),
        .sat_flag_o   (sat_flag_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic longint fdiv(input longint n, input longint d);
        longint q;
        q = n / d;
        if ((n % d) != 0 && n < 0) q = q - 1;
        return q;
    endfunction

    // Arithmetic lane model taken from the requirements.
    function automatic void lane_model(input int w, input bit uns, input int op,
                                       input longint raw, input int s,
                                       output longint res, output bit sat);
        longint mask, d, sv, p, hi, lo;
        mask = (longint'(1) << w) - 1;
        d    = longint'(1) << s;
        sv   = raw[w-1] ? raw - (mask + 1) : raw;
        hi   = (longint'(1) << (w - 1)) - 1;
        lo   = -hi - 1;
        sat  = 1'b0;
        case (op)
            0: res = (raw * d) & mask;
            1: begin
                if (uns) begin
                    p = raw * d;
                    if (p > mask) begin res = mask; sat = 1'b1; end
                    else res = p;
                end else begin
                    p = sv * d;
                    if (p > hi)      begin res = hi & mask; sat = 1'b1; end
                    else if (p < lo) begin res = lo & mask; sat = 1'b1; end
                    else res = p & mask;
                end
            end
            2: res = fdiv(sv, d) & mask;
            3: res = (s == 0) ? raw : (fdiv(sv + d / 2, d) & mask);
            4: res = raw / d;
            default: res = 0;
        endcase
    endfunction

    function automatic logic [31:0] pattern(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_8000;
            3: return 32'h7FFF_7FFF;
            4: return 32'h8080_7F01;
            5: return 32'h0001_FFFE;
            6: return 32'h4000_C000;
            7: return 32'h00FF_FF00;
            default: return (i * 32'h9E37_79B9) ^ (32'h1234_5678 >> i);
        endcase
    endfunction

    // Drives one request at the current falling edge and checks it one cycle later.
    task automatic run_vec(input int op, input int fmt, input bit use_reg, input int amt,
                           input logic [31:0] opnd, input bit clr);
        int w, n, s;
        bit uns, sat_any, lsat;
        longint lres;
        logic [31:0] exp;
        string tag;
        valid_i       = 1'b1;
        op_i          = 3'(op);
        fmt_i         = 2'(fmt);
        use_reg_amt_i = use_reg;
        imm_amt_i     = use_reg ? 5'(amt ^ 5'h15) : 5'(amt);
        reg_amt_i     = use_reg ? 5'(amt) : 5'(amt ^ 5'h0A);
        operand_i     = opnd;
        sat_clr_i     = clr;
        w   = (fmt == 0) ? 16 : (fmt == 1) ? 8 : 32;
        n   = 32 / w;
        uns = (fmt == 1);
        s   = amt & (w - 1);
        exp = '0;
        sat_any = 1'b0;
        for (int k = 0; k < n; k++) begin
            lane_model(w, uns, op, longint'((opnd >> (k * w)) & 32'((longint'(1) << w) - 1)),
                       s, lres, lsat);
            exp = exp | 32'(lres << (k * w));
            sat_any = sat_any | lsat;
        end
        if (sat_any) flag_exp = 1'b1;
        else if (clr) flag_exp = 1'b0;
        case (op)
            0: tag = "R1 R2 R3";
            1: tag = uns ? "R1 R2 R5" : "R1 R2 R4";
            2: tag = "R1 R2 R6";
            3: tag = "R1 R2 R7";
            4: tag = "R1 R2 R8";
            default: tag = "R12";
        endcase
        @(negedge clk);
        check(result_o === exp, tag, result_o, exp);
        check(sat_flag_o === flag_exp, "R9 flag", {31'd0, sat_flag_o}, {31'd0, flag_exp});
        check(valid_o === 1'b1, "R10 valid", {31'd0, valid_o}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] held;
        rst_n = 1'b0;
        valid_i = 1'b1; op_i = 3'd1; fmt_i = 2'd0; use_reg_amt_i = 1'b0;
        imm_amt_i = 5'd15; reg_amt_i = 5'd0; operand_i = 32'h7FFF_7FFF; sat_clr_i = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset state even with a clamping request applied
        check(result_o === 32'd0, "R11 result", result_o, 32'd0);
        check(valid_o === 1'b0, "R11 valid", {31'd0, valid_o}, 32'd0);
        check(sat_flag_o === 1'b0, "R11 flag", {31'd0, sat_flag_o}, 32'd0);
        rst_n = 1'b1;
        valid_i = 1'b0;
        @(negedge clk);
        for (int op = 0; op < 6; op++)
            for (int fmt = 0; fmt < 4; fmt++)
                for (int ur = 0; ur < 2; ur++)
                    for (int a = 0; a < 32; a++)
                        for (int p = 0; p < 16; p++)
                            run_vec(op, fmt, ur[0], a, pattern(p), ((a + p) % 5) == 0);
        // R10: idle cycle keeps the result and drops valid
        held = result_o;
        valid_i = 1'b0; op_i = 3'd1; fmt_i = 2'd0; imm_amt_i = 5'd15;
        use_reg_amt_i = 1'b0; operand_i = 32'h7FFF_8000; sat_clr_i = 1'b0;
        @(negedge clk);
        check(result_o === held, "R10 hold", result_o, held);
        check(valid_o === 1'b0, "R10 idle valid", {31'd0, valid_o}, 32'd0);
        check(sat_flag_o === flag_exp, "R10 idle flag", {31'd0, sat_flag_o}, {31'd0, flag_exp});
        // R9: set, then clear wins only without a new clamp
        run_vec(1, 0, 1'b0, 15, 32'h7FFF_0000, 1'b1);
        check(sat_flag_o === 1'b1, "R9 set over clear", {31'd0, sat_flag_o}, 32'd1);
        valid_i = 1'b0; sat_clr_i = 1'b1;
        @(negedge clk);
        check(sat_flag_o === 1'b0, "R9 clear", {31'd0, sat_flag_o}, 32'd0);
        sat_clr_i = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule